// File: doc/BRIEF.md
# Double-Buffered Asymmetric PWM Generator

This block drives one pulse-width-modulated output from a free-running up-counter. Software programs a period and a compare value, both counted in clock cycles. A polarity bit decides whether the compare value gives the high time or the low time of each period. An output-enable bit forces the pin low whenever it is clear. A run bit starts and freezes the counter.

Each timing value exists twice. The live copy is read by the counter and comparator. The staged copy can be written while the output runs. A staged value is committed on the cycle the counter wraps to zero, and only when that staged register has been written since the last commit. The period already in progress therefore always completes with its original timing. Writing a live register directly changes it at once, which is how the generator is set up while it is stopped.

All registers sit behind a small memory-mapped port. The port supports 32-bit and 16-bit writes and reads. Reads are combinational.

Top module: `apwm_dbuf`

## Requirements
- R1: After reset, every register reads 0, the counter is stopped and `pwm_out` is low.
- R2: A read with `rd_en` high returns the addressed register on `rdata` in the same cycle. The staged registers return the value still waiting to be committed. With `size_half` high, `addr[1]`=0 returns bits 15:0 and `addr[1]`=1 returns bits 31:16, both placed in `rdata[15:0]` with zeros above.
- R3: Register word offsets are: control 0x00, live period 0x04, live compare 0x08, staged period 0x0C, staged compare 0x10. A halfword write (`size_half`=1) takes `wdata[15:0]` and changes only the half selected by `addr[1]`. The control register is 16 bits wide, and a halfword write to its upper half is ignored.
- R4: While running, the counter steps by one per cycle from 0. On the cycle it holds period−1 it wraps to 0. A period of 0 or 1 wraps every cycle.
- R5: With control bit 0 (run) clear, the counter holds its value, so the output level does not change.
- R6: The output is registered. It reflects the counter and registers of the previous cycle. With control bit 2 (polarity) clear, it is high while counter < compare. A compare of 0 gives constant low, and a compare ≥ period gives constant high.
- R7: With control bit 2 set, the output is the inverse of the R6 waveform, so the compare value sets the low time.
- R8: With control bit 1 (output enable) clear, `pwm_out` is low in the following cycle, whatever the counter state.
- R9: A staged register is copied to its live register only on a wrap cycle, and only when it has been written since the last copy. Until then the live value and the running period are unchanged.
- R10: A staged write in the very cycle of a wrap is not committed by that wrap. It stays pending until the next wrap.
- R11: A write to a live register takes effect in the next cycle. If it coincides with a commit of the same register, the direct write wins and the pending flag is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | DATA_W | Write data |
| size_half | input | 1 | 1 = 16-bit access, 0 = 32-bit access |
| rdata | output | DATA_W | Read data, zero when `rd_en` is low |
| pwm_out | output | 1 | PWM output |

## Verification
Two events can land on the same edge: a counter wrap that commits staged values, and a software write to a staged or live register. The bench tracks the counter position in its own model. It waits until the next edge is a wrap, then issues a staged write in that cycle, and later a live write. Read-backs then show whether the new value stays pending (R10) or wins over the commit (R11). Random traffic with short periods hits the same collision many more times, and the bench checks every output cycle against the model.

// File: rtl/apwm_pkg.sv
package apwm_pkg;
  // word index of each register (byte offset / 4)
  typedef enum logic [2:0] {
    IDX_CTRL = 3'd0,
    IDX_APER = 3'd1,
    IDX_ACMP = 3'd2,
    IDX_SPER = 3'd3,
    IDX_SCMP = 3'd4
  } reg_idx_e;

  localparam int unsigned CTRL_W    = 16;
  localparam int unsigned CTRL_RUN  = 0;
  localparam int unsigned CTRL_MODE = 1;
  localparam int unsigned CTRL_POL  = 2;
endpackage

// File: rtl/apwm_regs.sv
module apwm_regs
  import apwm_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              size_half,
  input  logic              wrap,
  output logic [DATA_W-1:0] rdata,
  output logic              run,
  output logic              mode,
  output logic              pol,
  output logic [DATA_W-1:0] aper,
  output logic [DATA_W-1:0] acmp,
  output logic [1:0]        pend_vec
);
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned IDX_W  = ADDR_W - 2;
  localparam int unsigned NPAIR  = 2;

  logic [IDX_W-1:0] idx;
  logic             hi_sel;
  logic             addr_unused;
  assign idx         = addr[ADDR_W-1:2];
  assign hi_sel      = addr[1];
  assign addr_unused = addr[0];

  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old,
                                              input logic [DATA_W-1:0] nw,
                                              input logic half, input logic hi);
    if (!half)   return nw;
    else if (hi) return {nw[HALF_W-1:0], old[HALF_W-1:0]};
    else         return {old[DATA_W-1:HALF_W], nw[HALF_W-1:0]};
  endfunction

  logic [NPAIR-1:0][DATA_W-1:0] act_vec;
  logic [NPAIR-1:0][DATA_W-1:0] shd_vec;

  // live / staged pairs: index 0 = period, 1 = compare
  generate
    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
      localparam logic [IDX_W-1:0] ACT_IDX = IDX_W'(IDX_APER) + IDX_W'(k);
      localparam logic [IDX_W-1:0] SHD_IDX = IDX_W'(IDX_SPER) + IDX_W'(k);
      logic [DATA_W-1:0] act_q, act_d, shd_q, shd_d;
      logic              pend_q, pend_d;
      logic              act_en, shd_en, pend_en;
      logic              wr_act, wr_shd;

      assign wr_act = wr_en && (idx == ACT_IDX);
      assign wr_shd = wr_en && (idx == SHD_IDX);

      always_comb begin
        act_d  = act_q;
        act_en = 1'b0;
        if (wr_act) begin
          act_d  = merge(act_q, wdata, size_half, hi_sel);
          act_en = 1'b1;
        end else if (wrap && pend_q) begin
          act_d  = shd_q;
          act_en = 1'b1;
        end
        shd_en  = wr_shd;
        shd_d   = merge(shd_q, wdata, size_half, hi_sel);
        pend_en = wr_shd | wrap;
        pend_d  = wr_shd;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          act_q  <= '0;
          shd_q  <= '0;
          pend_q <= 1'b0;
        end else begin
          if (act_en)  act_q  <= act_d;
          if (shd_en)  shd_q  <= shd_d;
          if (pend_en) pend_q <= pend_d;
        end
      end

      assign act_vec[k]  = act_q;
      assign shd_vec[k]  = shd_q;
      assign pend_vec[k] = pend_q;
    end
  endgenerate

  // control register
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              ctrl_en;

  always_comb begin
    ctrl_en = wr_en && (idx == IDX_W'(IDX_CTRL)) && !(size_half && hi_sel);
    ctrl_d  = wdata[CTRL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  assign run  = ctrl_q[CTRL_RUN];
  assign mode = ctrl_q[CTRL_MODE];
  assign pol  = ctrl_q[CTRL_POL];
  assign aper = act_vec[0];
  assign acmp = act_vec[1];

  // read path
  logic [DATA_W-1:0] word;
  always_comb begin
    case (idx)
      IDX_W'(IDX_CTRL): word = DATA_W'(ctrl_q);
      IDX_W'(IDX_APER): word = act_vec[0];
      IDX_W'(IDX_ACMP): word = act_vec[1];
      IDX_W'(IDX_SPER): word = shd_vec[0];
      IDX_W'(IDX_SCMP): word = shd_vec[1];
      default:          word = '0;
    endcase
    if (!rd_en)         rdata = '0;
    else if (size_half) rdata = hi_sel ? DATA_W'(word[DATA_W-1:HALF_W])
                                       : DATA_W'(word[HALF_W-1:0]);
    else                rdata = word;
  end
endmodule

// File: rtl/apwm_timebase.sv
module apwm_timebase #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   next_ext;

  always_comb begin
    next_ext = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    wrap     = run && (next_ext >= {1'b0, period});
    cnt_d    = wrap ? '0 : next_ext[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (run) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/apwm_outstage.sv
module apwm_outstage #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode,
  input  logic             pol,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  output logic             pwm_out
);
  logic out_q, out_d, below;

  always_comb begin
    below = cnt < cmp;
    out_d = mode & (below ^ pol);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  assign pwm_out = out_q;
endmodule

// File: rtl/apwm_dbuf.sv
module apwm_dbuf #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              size_half,
  output logic [DATA_W-1:0] rdata,
  output logic              pwm_out
);
  localparam int unsigned CNT_W = DATA_W;

  logic              run, mode, pol, wrap;
  logic [DATA_W-1:0] aper, acmp;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        pend_vec;

  apwm_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .size_half(size_half), .wrap(wrap), .rdata(rdata),
    .run(run), .mode(mode), .pol(pol), .aper(aper), .acmp(acmp),
    .pend_vec(pend_vec)
  );

  apwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .run(run), .period(aper), .cnt(cnt), .wrap(wrap)
  );

  apwm_outstage #(.CNT_W(CNT_W)) u_out (
    .clk(clk), .rst_n(rst_n), .mode(mode), .pol(pol), .cnt(cnt), .cmp(acmp),
    .pwm_out(pwm_out)
  );
endmodule

// File: rtl/apwm_dbuf_chk.sv
module apwm_dbuf_chk
  import apwm_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic              run,
  input logic              mode,
  input logic [DATA_W-1:0] aper,
  input logic [DATA_W-1:0] cnt,
  input logic              wrap,
  input logic [1:0]        pend_vec,
  input logic              pwm_out
);
  logic wr_aper, wr_sper, wr_scmp;
  assign wr_aper = wr_en && (wr_idx == IDX_W'(IDX_APER));
  assign wr_sper = wr_en && (wr_idx == IDX_W'(IDX_SPER));
  assign wr_scmp = wr_en && (wr_idx == IDX_W'(IDX_SCMP));

  // R8
  mode_off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode |=> !pwm_out);

  // R5
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> (cnt == $past(cnt) + 1'b1));

  // R4
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));

  // R9
  period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap && !wr_aper) |=> $stable(aper));

  // R10
  pend_per_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sper |=> pend_vec[0]);

  // R10
  pend_cmp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_scmp |=> pend_vec[1]);

  // R9
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !wr_sper) |=> !pend_vec[0]);
endmodule

bind apwm_dbuf apwm_dbuf_chk #(.DATA_W(DATA_W), .IDX_W(ADDR_W - 2)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(addr[ADDR_W-1:2]),
  .run(run), .mode(mode), .aper(aper), .cnt(cnt), .wrap(wrap),
  .pend_vec(pend_vec), .pwm_out(pwm_out)
);

// File: tb/apwm_dbuf_bench.sv
module apwm_dbuf_bench;
  localparam logic [4:0] A_CTRL = 5'h00, A_APER = 5'h04, A_ACMP = 5'h08,
                         A_SPER = 5'h0C, A_SCMP = 5'h10;

  logic        clk, rst_n, wr_en, rd_en, size_half;
  logic [4:0]  addr;
  logic [31:0] wdata, rdata;
  logic        pwm_out;

  int errors = 0;
  int checks = 0;
  string cur_tag = "R1";

  // bench model state
  logic [15:0] m_ctrl;
  logic [31:0] m_aper, m_acmp, m_sper, m_scmp, m_cnt;
  logic        m_pp, m_pc, m_out;

  apwm_dbuf u_apwm_dbuf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .size_half(size_half), .rdata(rdata), .pwm_out(pwm_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic logic [31:0] bmerge(input logic [31:0] old, input logic [31:0] d,
                                         input logic h, input logic hi);
    if (!h)      return d;
    else if (hi) return {d[15:0], old[15:0]};
    else         return {old[31:16], d[15:0]};
  endfunction

  function automatic logic [31:0] m_read(input logic [4:0] a, input logic h);
    logic [31:0] w;
    case (a[4:2])
      3'd0:    w = {16'h0, m_ctrl};
      3'd1:    w = m_aper;
      3'd2:    w = m_acmp;
      3'd3:    w = m_sper;
      3'd4:    w = m_scmp;
      default: w = 32'h0;
    endcase
    if (h) return a[1] ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
    return w;
  endfunction

  // one clock cycle with optional write; output compared to the model
  task automatic tick(input logic we, input logic [4:0] a, input logic [31:0] d, input logic h);
    logic        wrap_m, o_n, pp_n, pc_n;
    logic [15:0] c_n;
    logic [31:0] ap_n, ac_n, sp_n, sc_n, cnt_n;
    logic [2:0]  ix;
    wr_en = we; addr = a; wdata = d; size_half = h;
    ix     = a[4:2];
    wrap_m = m_ctrl[0] && (({1'b0, m_cnt} + 33'd1) >= {1'b0, m_aper});
    o_n    = m_ctrl[1] & ((m_cnt < m_acmp) ^ m_ctrl[2]);
    cnt_n  = m_ctrl[0] ? (wrap_m ? 32'd0 : m_cnt + 32'd1) : m_cnt;
    c_n    = (we && ix == 3'd0 && !(h && a[1])) ? d[15:0] : m_ctrl;
    ap_n = m_aper; ac_n = m_acmp;
    if (we && ix == 3'd1) ap_n = bmerge(m_aper, d, h, a[1]);
    else if (wrap_m && m_pp) ap_n = m_sper;
    if (we && ix == 3'd2) ac_n = bmerge(m_acmp, d, h, a[1]);
    else if (wrap_m && m_pc) ac_n = m_scmp;
    sp_n = (we && ix == 3'd3) ? bmerge(m_sper, d, h, a[1]) : m_sper;
    sc_n = (we && ix == 3'd4) ? bmerge(m_scmp, d, h, a[1]) : m_scmp;
    pp_n = (we && ix == 3'd3) ? 1'b1 : (wrap_m ? 1'b0 : m_pp);
    pc_n = (we && ix == 3'd4) ? 1'b1 : (wrap_m ? 1'b0 : m_pc);
    @(posedge clk);
    m_out = o_n; m_cnt = cnt_n; m_ctrl = c_n; m_aper = ap_n; m_acmp = ac_n;
    m_sper = sp_n; m_scmp = sc_n; m_pp = pp_n; m_pc = pc_n;
    @(negedge clk);
    wr_en = 1'b0; size_half = 1'b0;
    check(cur_tag, {31'h0, pwm_out}, {31'h0, m_out});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 5'h0, 32'h0, 1'b0);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    tick(1'b1, a, d, 1'b0);
  endtask

  task automatic rd(input string tag, input logic [4:0] a, input logic h, input logic [31:0] exp);
    rd_en = 1'b1; addr = a; size_half = h;
    #1;
    check(tag, rdata, exp);
    rd_en = 1'b0; size_half = 1'b0;
  endtask

  task automatic count_high(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      idle(1);
      c += int'(pwm_out);
    end
  endtask

  // idle until the next tick is a wrap cycle
  task automatic align_wrap();
    for (int i = 0; i < 100; i++) begin
      if (({1'b0, m_cnt} + 33'd1) >= {1'b0, m_aper}) break;
      idle(1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int c, first;
    logic [4:0] ra;
    void'($urandom(32'd1234));
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; size_half = 1'b0;
    addr = '0; wdata = '0;
    m_ctrl = '0; m_aper = '0; m_acmp = '0; m_sper = '0; m_scmp = '0;
    m_cnt = '0; m_pp = 1'b0; m_pc = 1'b0; m_out = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1", {31'h0, pwm_out}, 32'h0);
    rd("R1", A_CTRL, 1'b0, 32'h0);
    rd("R1", A_APER, 1'b0, 32'h0);
    rd("R1", A_ACMP, 1'b0, 32'h0);
    rd("R1", A_SPER, 1'b0, 32'h0);
    rd("R1", A_SCMP, 1'b0, 32'h0);
    idle(3);

    // R3 halfword writes, R2 halfword reads
    cur_tag = "R3";
    tick(1'b1, A_SPER, 32'h0000_1234, 1'b1);
    tick(1'b1, A_SPER | 5'h2, 32'h0000_ABCD, 1'b1);
    rd("R3", A_SPER, 1'b0, 32'hABCD_1234);
    rd("R2", A_SPER | 5'h2, 1'b1, 32'h0000_ABCD);
    rd("R2", A_SPER, 1'b1, 32'h0000_1234);
    tick(1'b1, A_CTRL | 5'h2, 32'h0000_FFFF, 1'b1);
    rd("R3", A_CTRL, 1'b0, 32'h0);
    check("R3", {31'h0, pwm_out}, 32'h0);

    // R11 direct writes while stopped
    cur_tag = "R11";
    wr(A_APER, 32'd5);
    wr(A_ACMP, 32'd2);
    rd("R11", A_APER, 1'b0, 32'd5);
    rd("R11", A_ACMP, 1'b0, 32'd2);
    wr(A_SPER, 32'd5);
    wr(A_SCMP, 32'd2);

    // R6 basic waveform: period 5, compare 2
    cur_tag = "R6";
    wr(A_CTRL, 32'h3);
    idle(12);
    count_high(10, c);
    check("R6", c, 32'd4);

    // R9 staged update mid-period
    cur_tag = "R9";
    for (int i = 0; i < 10; i++) begin
      if (m_cnt == 32'd0) break;
      idle(1);
    end
    wr(A_SPER, 32'd8);
    wr(A_SCMP, 32'd6);
    rd("R9", A_APER, 1'b0, 32'd5);
    rd("R2", A_SPER, 1'b0, 32'd8);
    idle(6);
    rd("R9", A_APER, 1'b0, 32'd8);
    rd("R9", A_ACMP, 1'b0, 32'd6);
    idle(8);
    count_high(16, c);
    check("R9", c, 32'd12);

    // R7 inverted polarity
    cur_tag = "R7";
    wr(A_CTRL, 32'h7);
    idle(10);
    count_high(16, c);
    check("R7", c, 32'd4);

    // R8 output enable clear
    cur_tag = "R8";
    wr(A_CTRL, 32'h5);
    idle(2);
    count_high(12, c);
    check("R8", c, 32'd0);

    // R5 counter stopped
    cur_tag = "R5";
    wr(A_CTRL, 32'h6);
    idle(2);
    first = int'(pwm_out);
    count_high(10, c);
    check("R5", c, first * 10);

    // R6 compare corners with period 8
    cur_tag = "R6";
    wr(A_CTRL, 32'h3);
    wr(A_SCMP, 32'd0);
    idle(20);
    count_high(8, c);
    check("R6", c, 32'd0);
    wr(A_SCMP, 32'd20);
    idle(20);
    count_high(8, c);
    check("R6", c, 32'd8);
    wr(A_SCMP, 32'd8);
    idle(20);
    count_high(8, c);
    check("R6", c, 32'd8);
    wr(A_SCMP, 32'd3);
    idle(20);

    // R10 staged write in the wrap cycle
    cur_tag = "R10";
    align_wrap();
    wr(A_SPER, 32'd4);
    rd("R10", A_APER, 1'b0, 32'd8);
    rd("R10", A_SPER, 1'b0, 32'd4);
    idle(10);
    rd("R10", A_APER, 1'b0, 32'd4);

    // R11 direct write colliding with a commit
    cur_tag = "R11";
    wr(A_SPER, 32'd6);
    align_wrap();
    wr(A_APER, 32'd3);
    rd("R11", A_APER, 1'b0, 32'd3);
    idle(10);
    rd("R11", A_APER, 1'b0, 32'd3);

    // R4 tiny periods
    cur_tag = "R4";
    wr(A_APER, 32'd1);
    wr(A_ACMP, 32'd1);
    idle(3);
    count_high(8, c);
    check("R4", c, 32'd8);
    wr(A_APER, 32'd0);
    idle(3);
    count_high(8, c);
    check("R4", c, 32'd8);
    wr(A_ACMP, 32'd0);
    idle(3);
    count_high(8, c);
    check("R4", c, 32'd0);

    // random traffic (R4 outputs, R2 reads)
    cur_tag = "R4";
    for (int i = 0; i < 600; i++) begin
      int op;
      op = int'($urandom_range(0, 9));
      ra = 5'(4 * $urandom_range(0, 4));
      if (op < 3) begin
        if (ra == A_CTRL) wr(ra, {29'h0, 3'($urandom_range(0, 7))});
        else              wr(ra, 32'($urandom_range(0, 12)));
      end else if (op == 3) begin
        if ($urandom_range(0, 1) == 1) tick(1'b1, ra | 5'h2, 32'h0, 1'b1);
        else tick(1'b1, ra, 32'($urandom_range(0, 12)), 1'b1);
      end else if (op == 4) begin
        rd("R2", ra, 1'b0, m_read(ra, 1'b0));
        idle(1);
      end else begin
        idle(1);
      end
    end

    finish_run();
  end
endmodule